// File: doc/BRIEF.md
# SPI Register-Access Host Controller

This block is the host side of a four-wire SPI link to a byte-addressed register target. A client hands it one request through a ready/valid handshake. The request holds an operation (write, read, or both at once), a start register address, a byte count, and a divider setting. The engine then lowers chip select and sends a command byte, then the address byte, then the data bytes. Write bytes come from the client one at a time through a second ready/valid handshake. Bytes received from the target are handed back one at a time with a single-cycle strobe.

The serial clock is made inside the block by dividing the system clock. Each SCK level lasts `clk_div + 1` system cycles, so a full SCK period is 2×(`clk_div`+1) cycles. The bus runs in SPI mode 0: SCK rests low, MISO is sampled on the rising edge, and MOSI changes on the falling edge.

The target stores incoming bytes at consecutive addresses, so a burst covers a contiguous range. Short bursts of up to seven bytes are announced in the command byte. Longer ones use the target's open-ended streaming mode, and the engine ends them by raising chip select after the last requested byte.

Top module: `spi_reg_host`

## Requirements
- R1: After reset, and whenever reset is asserted in the middle of a frame, `spi_cs_n` is 1, `spi_sck` is 0, `busy` is 0, `rd_valid` is 0 and `req_ready` is 1.
- R2: A frame sends the command byte, then the 8-bit address byte, then the data bytes. Every byte goes out most significant bit first. Data byte i lands at register address `req_addr + i` modulo 256.
- R3: Command byte layout: bit 7 equals `req_op[1]` (write) and bit 6 equals `req_op[0]` (read). Bits 5:3 hold `req_len` when `req_len` is 1 to 7. Bits 2:0 are always 0.
- R4: When `req_len` is greater than 7, bits 5:3 of the command are 0 (streaming). Chip select rises after exactly `req_len` data bytes.
- R5: When `req_len` is 1 to 7, exactly `req_len` data bytes are clocked before chip select rises.
- R6: For a write, each data byte is taken from `wdata` in a cycle where `wdata_valid` and `wdata_ready` are both 1. While `wdata_valid` is low the engine waits with SCK low, and no byte is skipped or repeated.
- R7: For a read (`req_op[0]`=1), each received data byte appears on `rd_data` with a one-cycle `rd_valid` pulse, in address order and while chip select is low.
- R8: With `req_op` = 2'b11, the engine returns the old contents of each register and writes the new byte to it in the same frame.
- R9: For a write-only request (`req_op` = 2'b10), `rd_valid` never pulses, whatever MISO carries.
- R10: For a read-only request (`req_op` = 2'b01), MOSI is 0 throughout the data phase.
- R11: SCK is low whenever chip select is high. Within a byte, SCK has a period of 2×(`clk_div`+1) system cycles.
- R12: Between two frames, chip select stays high for at least 2×(`clk_div`+1) system cycles.
- R13: `busy` is 1 exactly while chip select is low.
- R14: A request with `req_op` = 2'b00 or `req_len` = 0 is accepted, and chip select never falls for it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | DIV_W | Half-period of SCK minus one, in system cycles; captured when a request is accepted |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle and able to accept a request |
| req_op | input | 2 | Bit 1 = write, bit 0 = read |
| req_addr | input | 8 | Start register address |
| req_len | input | LEN_W | Number of data bytes |
| wdata_valid | input | 1 | Client has a write byte available |
| wdata_ready | output | 1 | Write byte consumed this cycle |
| wdata | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte |
| busy | output | 1 | Frame in progress (chip select low) |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the target |
| spi_miso | input | 1 | Serial data from the target |

## Verification
The bench builds the block with its default widths: an 8-bit divider and an 8-bit length. It then varies `clk_div` from 0 to 3 at run time, so both the fastest SCK and slower, stretched half-periods are checked for period and gap. The 8-bit length lets bursts of 8 to 10 bytes push the engine past the three-bit count field and into streaming mode. Bursts starting at 0xFE and 0xFF check the address wrap in a behavioural target model that follows the command format.

// File: rtl/spi_reg_host_pkg.sv
package spi_reg_host_pkg;

    localparam int BYTE_W = 8;
    localparam int BURST_FIELD_MAX = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_LOAD,
        ST_END,
        ST_GAP
    } host_state_e;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_ADDR,
        PH_DATA
    } frame_phase_e;

endpackage

// File: rtl/spi_sck_divider.sv
module spi_sck_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == div);
        cnt_d = cnt_q;
        if (!en || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/spi_cmd_encoder.sv
module spi_cmd_encoder
    import spi_reg_host_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic [1:0]        op,
    input  logic [LEN_W-1:0]  len,
    output logic [BYTE_W-1:0] cmd
);
    logic       fits;
    logic [2:0] count_field;

    always_comb begin
        fits        = (len != '0) && (len <= LEN_W'(BURST_FIELD_MAX));
        count_field = fits ? len[2:0] : 3'd0;
        cmd         = {op[1], op[0], count_field, 3'b000};
    end
endmodule

// File: rtl/spi_reg_host.sv
module spi_reg_host
    import spi_reg_host_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int LEN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [7:0]        req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              wdata_valid,
    output logic              wdata_ready,
    input  logic [7:0]        wdata,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int BITCNT_W = $clog2(BYTE_W);

    typedef struct packed {
        host_state_e          state;
        frame_phase_e         phase;
        logic                 sck;
        logic                 cs_n;
        logic [BYTE_W-1:0]    tx;
        logic [BYTE_W-1:0]    rx;
        logic [BITCNT_W-1:0]  bitn;
        logic [LEN_W-1:0]     left;
        logic                 wr;
        logic                 rd;
        logic [BYTE_W-1:0]    addr;
        logic [DIV_W-1:0]     div;
        logic                 half;
        logic                 rd_valid;
        logic [BYTE_W-1:0]    rd_data;
    } host_regs_t;

    localparam host_regs_t REGS_RST = '{
        state:    ST_IDLE,
        phase:    PH_CMD,
        sck:      1'b0,
        cs_n:     1'b1,
        tx:       '0,
        rx:       '0,
        bitn:     '0,
        left:     '0,
        wr:       1'b0,
        rd:       1'b0,
        addr:     '0,
        div:      '0,
        half:     1'b0,
        rd_valid: 1'b0,
        rd_data:  '0
    };

    host_regs_t d, q;
    logic              tick;
    logic              clk_en;
    logic [BYTE_W-1:0] cmd_byte;
    logic              last_bit;
    logic              data_rd_only;
    logic [DIV_W-1:0]  div_cur;

    spi_cmd_encoder #(.LEN_W(LEN_W)) u_cmd (
        .op  (req_op),
        .len (req_len),
        .cmd (cmd_byte)
    );

    spi_sck_divider #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (clk_en),
        .div   (q.div),
        .tick  (tick)
    );

    always_comb begin
        d           = q;
        d.rd_valid  = 1'b0;
        wdata_ready = 1'b0;
        clk_en      = (q.state == ST_SHIFT) || (q.state == ST_END) || (q.state == ST_GAP);
        last_bit    = (q.bitn == BITCNT_W'(BYTE_W - 1));

        case (q.state)
            ST_IDLE: begin
                if (req_valid && (req_op != 2'b00) && (req_len != '0)) begin
                    d.state = ST_SHIFT;
                    d.phase = PH_CMD;
                    d.cs_n  = 1'b0;
                    d.sck   = 1'b0;
                    d.tx    = cmd_byte;
                    d.bitn  = '0;
                    d.left  = req_len;
                    d.wr    = req_op[1];
                    d.rd    = req_op[0];
                    d.addr  = req_addr;
                    d.div   = clk_div;
                end
            end

            ST_SHIFT: begin
                if (tick) begin
                    if (!q.sck) begin
                        d.sck = 1'b1;
                        d.rx  = {q.rx[BYTE_W-2:0], spi_miso};
                    end else begin
                        d.sck  = 1'b0;
                        d.bitn = q.bitn + 1'b1;
                        d.tx   = {q.tx[BYTE_W-2:0], 1'b0};
                        if (last_bit) begin
                            case (q.phase)
                                PH_CMD: begin
                                    d.tx    = q.addr;
                                    d.phase = PH_ADDR;
                                end
                                PH_ADDR: begin
                                    d.phase = PH_DATA;
                                    d.state = ST_LOAD;
                                end
                                default: begin
                                    d.rd_valid = q.rd;
                                    d.rd_data  = q.rx;
                                    d.left     = q.left - 1'b1;
                                    d.state    = (q.left == LEN_W'(1)) ? ST_END : ST_LOAD;
                                end
                            endcase
                        end
                    end
                end
            end

            ST_LOAD: begin
                if (!q.wr || wdata_valid) begin
                    d.tx        = q.wr ? wdata : '0;
                    wdata_ready = q.wr;
                    d.state     = ST_SHIFT;
                end
            end

            ST_END: begin
                if (tick) begin
                    d.cs_n  = 1'b1;
                    d.half  = 1'b0;
                    d.state = ST_GAP;
                end
            end

            ST_GAP: begin
                if (tick) begin
                    if (q.half) begin
                        d.state = ST_IDLE;
                    end else begin
                        d.half = 1'b1;
                    end
                end
            end

            default: begin
                d = REGS_RST;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= REGS_RST;
        end else begin
            q <= d;
        end
    end

    assign req_ready    = (q.state == ST_IDLE);
    assign busy         = (q.state != ST_IDLE) && (q.state != ST_GAP);
    assign rd_valid     = q.rd_valid;
    assign rd_data      = q.rd_data;
    assign spi_sck      = q.sck;
    assign spi_cs_n     = q.cs_n;
    assign spi_mosi     = q.tx[BYTE_W-1];
    assign data_rd_only = (q.state == ST_SHIFT) && (q.phase == PH_DATA) && q.rd && !q.wr;
    assign div_cur      = q.div;
endmodule

// File: rtl/spi_reg_host_chk.sv
module spi_reg_host_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             sck,
    input logic             mosi,
    input logic             busy,
    input logic             req_ready,
    input logic             rd_valid,
    input logic             wdata_ready,
    input logic             data_rd_only,
    input logic [DIV_W-1:0] div_q
);
    localparam int HC_W  = DIV_W + 1;
    localparam int GAP_W = DIV_W + 2;

    logic             prev_sck_q;
    logic             prev_cs_q;
    logic             seen_q;
    logic [HC_W-1:0]  hc_q;
    logic [GAP_W-1:0] gap_q;
    logic [DIV_W-1:0] old_div_q;
    logic [GAP_W-1:0] gap_min;

    assign gap_min = {1'b0, old_div_q, 1'b0} + GAP_W'(2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_sck_q <= 1'b0;
            prev_cs_q  <= 1'b1;
            seen_q     <= 1'b0;
            hc_q       <= '0;
            gap_q      <= '0;
            old_div_q  <= '0;
        end else begin
            prev_sck_q <= sck;
            prev_cs_q  <= cs_n;
            if (!cs_n) seen_q <= 1'b1;
            if (cs_n || (sck != prev_sck_q)) hc_q <= '0;
            else if (hc_q != '1) hc_q <= hc_q + 1'b1;
            if (!cs_n) gap_q <= '0;
            else if (gap_q != '1) gap_q <= gap_q + 1'b1;
            if (cs_n && !prev_cs_q) old_div_q <= div_q;
        end
    end

    p_sck_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    p_half_period_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && (sck != prev_sck_q)) |-> (hc_q >= HC_W'(div_q)));

    p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (cs_n && !sck));

    p_busy_cs_r13: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (busy == !cs_n));

    p_rd_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !cs_n);

    p_mosi_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd_only |-> !mosi);

    p_load_sck_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wdata_ready |-> (!cs_n && !sck));

    p_cs_gap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && prev_cs_q && seen_q) |-> (gap_q >= gap_min));
endmodule

bind spi_reg_host spi_reg_host_chk #(.DIV_W(DIV_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (spi_cs_n),
    .sck          (spi_sck),
    .mosi         (spi_mosi),
    .busy         (busy),
    .req_ready    (req_ready),
    .rd_valid     (rd_valid),
    .wdata_ready  (wdata_ready),
    .data_rd_only (data_rd_only),
    .div_q        (div_cur)
);

// File: tb/spi_reg_host_tb.sv
`timescale 1ns/1ps
module spi_reg_host_tb;
    localparam int DIV_W = 8;
    localparam int LEN_W = 8;

    // op[29:28] addr[27:20] len[19:12] div[11:8] seed[7:0]
    localparam int NVEC = 8;
    localparam logic [29:0] VEC [NVEC] = '{
        {2'b10, 8'h10, 8'd1,  4'd0, 8'h11},
        {2'b01, 8'h20, 8'd3,  4'd1, 8'h00},
        {2'b11, 8'h30, 8'd7,  4'd2, 8'h40},
        {2'b10, 8'hFE, 8'd4,  4'd0, 8'h80},
        {2'b01, 8'h50, 8'd10, 4'd0, 8'h00},
        {2'b11, 8'h60, 8'd9,  4'd1, 8'hC0},
        {2'b10, 8'h70, 8'd8,  4'd3, 8'h33},
        {2'b01, 8'hFF, 8'd2,  4'd0, 8'h00}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DIV_W-1:0] clk_div = '0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [1:0] req_op = 2'b00;
    logic [7:0] req_addr = 8'h00;
    logic [LEN_W-1:0] req_len = '0;
    logic wdata_valid;
    logic wdata_ready;
    logic [7:0] wdata;
    logic rd_valid;
    logic [7:0] rd_data;
    logic busy;
    logic spi_sck, spi_cs_n, spi_mosi;
    logic spi_miso = 1'b0;

    always #10 clk = ~clk;

    spi_reg_host #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .clk_div(clk_div),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_len(req_len),
        .wdata_valid(wdata_valid), .wdata_ready(wdata_ready), .wdata(wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int cyc = 0;
    int wcons = 0;
    int wbase = 0;
    logic [7:0] wseed = 8'h00;
    bit stall_mode = 1'b0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (wdata_valid && wdata_ready) wcons <= wcons + 1;
    end
    assign wdata_valid = stall_mode ? cyc[1] : 1'b1;
    assign wdata = wseed + 8'(wcons - wbase);

    // behavioural register target
    int gen = 0;
    int wgen [256];
    logic [7:0] tval [256];
    int t_bit = 0, t_byte = 0, t_nbytes = 0;
    logic [7:0] t_sr = 8'h00, t_cmd = 8'h00, t_addr = 8'h00, t_out = 8'h00, t_rxor = 8'h00;

    function automatic logic [7:0] pat(input logic [7:0] a);
        return (8'(a * 8'd7) + 8'd3) ^ 8'h5C;
    endfunction

    function automatic logic [7:0] mval(input logic [7:0] a);
        return (wgen[a] == gen) ? tval[a] : pat(a);
    endfunction

    initial begin
        for (int i = 0; i < 256; i++) begin
            wgen[i] = -1;
            tval[i] = 8'h00;
        end
    end

    always @(negedge spi_cs_n) begin
        t_bit = 0; t_byte = 0; t_nbytes = 0; t_rxor = 8'h00;
    end

    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            t_sr = {t_sr[6:0], spi_mosi};
            t_bit++;
            if (t_bit == 8) begin
                t_bit = 0;
                if (t_byte == 0) t_cmd = t_sr;
                else if (t_byte == 1) t_addr = t_sr;
                else begin
                    if (t_cmd[7]) begin
                        tval[t_addr] = t_sr;
                        wgen[t_addr] = gen;
                    end
                    t_rxor = t_rxor | t_sr;
                    t_addr = t_addr + 8'd1;
                    t_nbytes++;
                end
                t_byte++;
            end
        end
    end

    always @(negedge spi_sck) begin
        if (!spi_cs_n) begin
            if (t_bit == 0 && t_byte >= 2) t_out = mval(t_addr);
            else t_out = {t_out[6:0], 1'b0};
            spi_miso = t_out[7];
        end
    end

    // port monitors
    logic prev_cs = 1'b1, prev_sck = 1'b0;
    int rise_cyc = 0, last_gap = 0, nrise = 0, r0 = 0, r1 = 0, nfall = 0;
    int idle_viol = 0, busy_viol = 0, rd_n = 0;
    logic [7:0] rd_buf [16];
    always @(negedge clk) begin
        if (spi_cs_n && !prev_cs) rise_cyc = cyc;
        if (!spi_cs_n && prev_cs) begin
            last_gap = cyc - rise_cyc;
            nrise = 0;
            nfall++;
        end
        if (spi_sck && !prev_sck && !spi_cs_n) begin
            if (nrise == 0) r0 = cyc;
            if (nrise == 1) r1 = cyc;
            nrise++;
        end
        if (rst_n && spi_cs_n && spi_sck) idle_viol++;
        if (rst_n && (busy == spi_cs_n)) busy_viol++;
        if (rst_n && rd_valid) begin
            if (rd_n < 16) rd_buf[rd_n] = rd_data;
            rd_n++;
        end
        prev_cs = spi_cs_n;
        prev_sck = spi_sck;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_accept();
        int to = 0;
        while (!req_ready && to < 5000) begin
            @(negedge clk);
            to++;
        end
        @(negedge clk);
    endtask

    task automatic wait_frame_end();
        int to = 0;
        while (spi_cs_n && to < 20) begin
            @(negedge clk);
            to++;
        end
        to = 0;
        while (!spi_cs_n && to < 20000) begin
            @(negedge clk);
            to++;
        end
        to = 0;
        while (!req_ready && to < 200) begin
            @(negedge clk);
            to++;
        end
    endtask

    task automatic run_req(input logic [1:0] op, input logic [7:0] addr, input int len,
                           input int dv, input logic [7:0] seed, input bit stall);
        logic [7:0] ecmd;
        @(negedge clk);
        gen++;
        clk_div = DIV_W'(dv);
        wseed = seed;
        wbase = wcons;
        stall_mode = stall;
        rd_n = 0;
        req_op = op; req_addr = addr; req_len = LEN_W'(len);
        req_valid = 1'b1;
        wait_accept();
        req_valid = 1'b0;
        wait_frame_end();
        ecmd = {op, (len >= 1 && len <= 7) ? 3'(len) : 3'd0, 3'b000};
        chk(t_cmd == ecmd, (len > 7) ? "R4" : "R3", "command byte", t_cmd, ecmd);
        chk(t_nbytes == len, (len > 7) ? "R4" : "R5", "data bytes clocked", t_nbytes, len);
        chk((r1 - r0) == 2 * (dv + 1), "R11", "sck period", r1 - r0, 2 * (dv + 1));
        if (op[1]) begin
            for (int i = 0; i < len; i++) begin
                logic [7:0] a;
                a = addr + 8'(i);
                chk(mval(a) == seed + 8'(i), op[0] ? "R8" : "R2", "written register", mval(a), seed + 8'(i));
            end
            chk((wcons - wbase) == len, "R6", "write bytes consumed", wcons - wbase, len);
        end
        if (op[0]) begin
            chk(rd_n == len, "R7", "read strobes", rd_n, len);
            for (int i = 0; i < len && i < 16; i++) begin
                logic [7:0] a;
                a = addr + 8'(i);
                chk(rd_buf[i] == pat(a), op[1] ? "R8" : "R7", "read byte", rd_buf[i], pat(a));
            end
        end else begin
            chk(rd_n == 0, "R9", "rd_valid during write-only", rd_n, 0);
        end
        if (op == 2'b01) chk(t_rxor == 8'h00, "R10", "mosi in read data phase", t_rxor, 0);
        stall_mode = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(spi_cs_n == 1'b1, "R1", "cs_n in reset", spi_cs_n, 1);
        chk(spi_sck == 1'b0, "R1", "sck in reset", spi_sck, 0);
        chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
        chk(req_ready == 1'b1, "R1", "req_ready in reset", req_ready, 1);
        chk(rd_valid == 1'b0, "R1", "rd_valid in reset", rd_valid, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            run_req(VEC[v][29:28], VEC[v][27:20], int'(VEC[v][19:12]),
                    int'(VEC[v][11:8]), VEC[v][7:0], 1'b0);
        end

        // R6: write with the data source stalling
        run_req(2'b10, 8'h90, 5, 1, 8'h21, 1'b1);
        run_req(2'b11, 8'hA0, 9, 0, 8'h05, 1'b1);

        // R12: back-to-back requests
        begin
            @(negedge clk);
            gen++;
            clk_div = DIV_W'(2);
            wbase = wcons; wseed = 8'h77;
            req_op = 2'b10; req_addr = 8'hB0; req_len = LEN_W'(1);
            req_valid = 1'b1;
            wait_accept();
            req_op = 2'b01; req_addr = 8'hC0;
            wait_accept();
            req_valid = 1'b0;
            wait_frame_end();
            chk(last_gap >= 6, "R12", "cs_n high gap", last_gap, 6);
        end

        // R14: null requests
        begin
            int f0;
            f0 = nfall;
            @(negedge clk);
            req_op = 2'b00; req_addr = 8'h10; req_len = LEN_W'(3);
            req_valid = 1'b1;
            wait_accept();
            req_op = 2'b10; req_len = '0;
            wait_accept();
            req_valid = 1'b0;
            repeat (20) @(negedge clk);
            chk(nfall == f0, "R14", "cs falls for null requests", nfall - f0, 0);
            chk(req_ready == 1'b1, "R14", "ready after null requests", req_ready, 1);
        end

        // R1: reset in the middle of a frame
        begin
            @(negedge clk);
            gen++;
            clk_div = DIV_W'(1);
            req_op = 2'b01; req_addr = 8'h40; req_len = LEN_W'(10);
            req_valid = 1'b1;
            wait_accept();
            req_valid = 1'b0;
            repeat (40) @(negedge clk);
            chk(spi_cs_n == 1'b0, "R13", "frame active before reset", spi_cs_n, 0);
            rst_n = 1'b0;
            #1;
            chk(spi_cs_n == 1'b1, "R1", "cs_n after mid-frame reset", spi_cs_n, 1);
            chk(spi_sck == 1'b0, "R1", "sck after mid-frame reset", spi_sck, 0);
            chk(busy == 1'b0, "R1", "busy after mid-frame reset", busy, 0);
            chk(req_ready == 1'b1, "R1", "ready after mid-frame reset", req_ready, 1);
            repeat (2) @(negedge clk);
            rst_n = 1'b1;
            repeat (2) @(negedge clk);
        end

        // one more frame after the reset
        run_req(2'b11, 8'h08, 3, 0, 8'hE0, 1'b0);

        chk(idle_viol == 0, "R11", "sck high with cs_n high", idle_viol, 0);
        chk(busy_viol == 0, "R13", "busy vs chip select mismatches", busy_viol, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule